// File: doc/BRIEF.md
# Command-Word Driven 12-Bit General-Purpose Port

This block is a twelve-pin digital port that is controlled by 16-bit command words. The low nibble of each word selects an operation. The upper twelve bits carry one bit per pin: bit 4 maps to pin 0, up through bit 15, which maps to pin 11. There are three operations. The first loads the output value register. The second loads the direction register. The third takes a snapshot of the pin inputs so that a serial front end can shift it out on the transaction that follows.

A command is acted on only in a cycle where the load strobe is high. The serial front end raises that strobe once a complete word has been assembled.

Pins 4 through 11 share their pads with analog converter channels. Pin 11 pairs with channel 5 and pin 4 pairs with channel 12, so pin k pairs with channel 16−k. The digital driver on a shared pad may switch on only when two things hold: the pin is programmed as an output, and the paired converter channel is reported as high-impedance. This keeps the two drivers from fighting.

Top module: `gpx_port12`

## Requirements
- R1: While reset is held high, and on the first cycle after it is released, every output enable is 0 (all pins are inputs), the output value register reads 0, the snapshot reads 0 and snapshot-valid is 0.
- R2: In a cycle where load is high and command bits [3:0] equal 4'b1101, command bits [15:4] are written to the output value register, with bit 4 going to pin 0 and bit 15 going to pin 11. The new value appears on `pin_out_o` in the next cycle, and loads on consecutive cycles each take effect.
- R3: In a cycle where load is high and bits [3:0] equal 4'b1111, bits [15:4] are written to the direction register, with bit 4 for pin 0 and bit 15 for pin 11. A bit set to 1 makes that pin an output and a bit set to 0 makes it an input. For pins 0 to 3, the output enable equals the direction bit from the next cycle onward.
- R4: For shared pin 4+j (j = 0..7), the output enable is high only when that pin's direction bit is 1 and `dac_hiz_i[j]` is 1. The enable follows a change in `dac_hiz_i` in the same cycle.
- R5: In a cycle where load is high and bits [3:0] equal 4'b1110, `pin_in_i` is captured. In the next cycle `cap_data_o` holds that value and `cap_valid_o` is high. Pin 0 lands in `cap_data_o` bit 0, which is command position 4.
- R6: `cap_valid_o` is high only in the cycle right after a capture command. Between captures, `cap_data_o` keeps its value even when the pin inputs change.
- R7: Any other address, or any cycle with load low, leaves the output value register, the direction register and the snapshot unchanged and does not raise `cap_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 16 | Command word: [3:0] operation code, [15:4] per-pin data |
| load_i | input | 1 | Strobe: act on `cmd_i` this cycle |
| pin_in_i | input | 12 | Sampled pad input levels, bit k = pin k |
| dac_hiz_i | input | 8 | Bit j high when the converter channel paired with pin 4+j is high-impedance |
| pin_out_o | output | 12 | Output value register, bit k = pin k |
| pin_oe_o | output | 12 | Digital driver enable per pin |
| cap_data_o | output | 12 | Pin snapshot for the serial front end |
| cap_valid_o | output | 1 | One-cycle pulse when a new snapshot is ready |

## Verification
The bench probes the shared-pad gate in both directions. If the pairing were reversed (pin 4 gated by the channel-5 status), driving a single `dac_hiz_i` bit would enable the wrong pin. If the gate were missing, a shared pin would drive into a live converter. A capture followed by pin changes with no new command catches two faults: a snapshot that is transparent to the pins, and a valid flag that stretches past one cycle. Unused operation codes, and valid codes presented with load low, catch a decoder that ignores the strobe or matches only part of the code. Random traffic with back-to-back loads catches writes that are lost or delayed by a cycle.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int GPX_ADDR_W   = 4;
    localparam int GPX_NPINS    = 12;
    localparam int GPX_NSHARED  = 8;
    localparam int GPX_CMD_W    = GPX_ADDR_W + GPX_NPINS;
    localparam int GPX_FIRST_SH = GPX_NPINS - GPX_NSHARED;

    localparam logic [GPX_ADDR_W-1:0] OPC_SET_OUT = 4'b1101;
    localparam logic [GPX_ADDR_W-1:0] OPC_SNAP    = 4'b1110;
    localparam logic [GPX_ADDR_W-1:0] OPC_SET_DIR = 4'b1111;

    typedef logic [GPX_NPINS-1:0] pinvec_t;

    typedef struct packed {
        logic    set_out;
        logic    set_dir;
        logic    snap;
        pinvec_t payload;
    } gpx_op_t;

    function automatic gpx_op_t gpx_decode(input logic [GPX_CMD_W-1:0] word,
                                           input logic strobe);
        gpx_op_t op;
        logic [GPX_ADDR_W-1:0] code;
        code       = word[GPX_ADDR_W-1:0];
        op.payload = word[GPX_CMD_W-1:GPX_ADDR_W];
        op.set_out = strobe && (code == OPC_SET_OUT);
        op.set_dir = strobe && (code == OPC_SET_DIR);
        op.snap    = strobe && (code == OPC_SNAP);
        return op;
    endfunction

endpackage

// File: rtl/gpx_cmd_decode.sv
module gpx_cmd_decode
    import gpx_pkg::*;
(
    input  logic [GPX_CMD_W-1:0] cmd_i,
    input  logic                 load_i,
    output gpx_op_t              op_o
);

    always_comb begin
        op_o = gpx_decode(cmd_i, load_i);
    end

endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
    import gpx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  gpx_op_t op_i,
    output pinvec_t out_q,
    output pinvec_t dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            if (op_i.set_out) out_q <= op_i.payload;
            if (op_i.set_dir) dir_q <= op_i.payload;
        end
    end

    // R2: a value write lands one cycle later
    a_r2_out_write: assert property (@(posedge clk) disable iff (rst)
        op_i.set_out |=> out_q == $past(op_i.payload));

    // R3: a direction write lands one cycle later
    a_r3_dir_write: assert property (@(posedge clk) disable iff (rst)
        op_i.set_dir |=> dir_q == $past(op_i.payload));

    // R7: no value write means the value register holds
    a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
        !op_i.set_out |=> $stable(out_q));

    // R7: no direction write means the direction register holds
    a_r7_dir_hold: assert property (@(posedge clk) disable iff (rst)
        !op_i.set_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpx_capture.sv
module gpx_capture
    import gpx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    snap_i,
    input  pinvec_t pins_i,
    output pinvec_t snap_q,
    output logic    snap_vld_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q     <= '0;
            snap_vld_q <= 1'b0;
        end else begin
            snap_vld_q <= snap_i;
            if (snap_i) snap_q <= pins_i;
        end
    end

    // R5: a capture yields the sampled pins and a valid flag next cycle
    a_r5_snap_result: assert property (@(posedge clk) disable iff (rst)
        snap_i |=> (snap_vld_q && snap_q == $past(pins_i)));

    // R6: valid only follows a capture command
    a_r6_valid_cause: assert property (@(posedge clk) disable iff (rst)
        !snap_i |=> !snap_vld_q);

    // R6: snapshot holds between captures
    a_r6_snap_hold: assert property (@(posedge clk) disable iff (rst)
        !snap_vld_q |-> $stable(snap_q));

endmodule

// File: rtl/gpx_oe_gate.sv
module gpx_oe_gate
    import gpx_pkg::*;
(
    input  pinvec_t                dir_i,
    input  logic [GPX_NSHARED-1:0] dac_hiz_i,
    output pinvec_t                oe_o
);

    for (genvar k = 0; k < GPX_NPINS; k++) begin : g_pin
        if (k < GPX_FIRST_SH) begin : g_dedicated
            assign oe_o[k] = dir_i[k];
        end else begin : g_shared
            assign oe_o[k] = dir_i[k] & dac_hiz_i[k - GPX_FIRST_SH];
        end
    end

endmodule

// File: rtl/gpx_port12.sv
module gpx_port12
    import gpx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GPX_CMD_W-1:0]   cmd_i,
    input  logic                   load_i,
    input  logic [GPX_NPINS-1:0]   pin_in_i,
    input  logic [GPX_NSHARED-1:0] dac_hiz_i,
    output logic [GPX_NPINS-1:0]   pin_out_o,
    output logic [GPX_NPINS-1:0]   pin_oe_o,
    output logic [GPX_NPINS-1:0]   cap_data_o,
    output logic                   cap_valid_o
);

    gpx_op_t op;
    pinvec_t dir_q;

    gpx_cmd_decode u_dec (
        .cmd_i  (cmd_i),
        .load_i (load_i),
        .op_o   (op)
    );

    gpx_port_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op),
        .out_q (pin_out_o),
        .dir_q (dir_q)
    );

    gpx_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .snap_i     (op.snap),
        .pins_i     (pin_in_i),
        .snap_q     (cap_data_o),
        .snap_vld_q (cap_valid_o)
    );

    gpx_oe_gate u_gate (
        .dir_i     (dir_q),
        .dac_hiz_i (dac_hiz_i),
        .oe_o      (pin_oe_o)
    );

    // R1: reset leaves every pad undriven
    a_r1_reset_inputs: assert property (@(posedge clk)
        rst |=> pin_oe_o == '0);

    // R4: a shared pad never drives while its converter channel is active
    for (genvar j = 0; j < GPX_NSHARED; j++) begin : g_chk
        a_r4_shared_gate: assert property (@(posedge clk) disable iff (rst)
            pin_oe_o[GPX_FIRST_SH + j] |-> dac_hiz_i[j]);
    end

endmodule

// File: tb/sim_gpx_port12.sv
module sim_gpx_port12;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cmd;
    logic        load;
    logic [11:0] pin_in;
    logic [7:0]  dac_hiz;
    logic [11:0] pin_out, pin_oe, cap_data;
    logic        cap_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [11:0] m_out, m_dir, m_cap;
    logic        m_vld;

    always #10 clk = ~clk;

    gpx_port12 u0 (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .load_i      (load),
        .pin_in_i    (pin_in),
        .dac_hiz_i   (dac_hiz),
        .pin_out_o   (pin_out),
        .pin_oe_o    (pin_oe),
        .cap_data_o  (cap_data),
        .cap_valid_o (cap_valid)
    );

    function automatic logic [11:0] exp_oe(input logic [11:0] dir, input logic [7:0] hiz);
        logic [11:0] r;
        for (int k = 0; k < 12; k++)
            r[k] = (k < 4) ? dir[k] : (dir[k] & hiz[k-4]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one cycle: present inputs at negedge, model update after posedge, check at next negedge
    task automatic step(input logic [15:0] c, input logic l);
        cmd  = c;
        load = l;
        @(posedge clk);
        if (l && c[3:0] == 4'b1101) m_out = c[15:4];
        if (l && c[3:0] == 4'b1111) m_dir = c[15:4];
        m_vld = l && c[3:0] == 4'b1110;
        if (m_vld) m_cap = pin_in;
        @(negedge clk);
        load = 1'b0;
        check("R2/R7 pin_out", pin_out, m_out);
        check("R3/R4 pin_oe", pin_oe, exp_oe(m_dir, dac_hiz));
        check("R5/R6 cap_data", cap_data, m_cap);
        check("R5/R6 cap_valid", {11'b0, cap_valid}, {11'b0, m_vld});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cmd = '0; load = 1'b0; pin_in = 12'hFFF; dac_hiz = 8'hFF;
        m_out = '0; m_dir = '0; m_cap = '0; m_vld = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        check("R1 oe", pin_oe, 12'h000);
        check("R1 out", pin_out, 12'h000);
        check("R1 valid", {11'b0, cap_valid}, 12'h000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cap", cap_data, 12'h000);

        // R2: bit 4 -> pin 0 ordering
        step({12'hA5C, 4'b1101}, 1'b1);
        check("R2 value", pin_out, 12'hA5C);
        step({12'h001, 4'b1101}, 1'b1);
        check("R2 lsb", pin_out, 12'h001);

        // R3/R4: all outputs, converter channels active -> only dedicated pins
        dac_hiz = 8'h00;
        step({12'hFFF, 4'b1111}, 1'b1);
        check("R3 dedicated", pin_oe, 12'h00F);
        // R4: one channel released, pairing check
        dac_hiz = 8'h01; #1;
        check("R4 pin4 only", pin_oe, 12'h01F);
        dac_hiz = 8'h80; #1;
        check("R4 pin11 only", pin_oe, 12'h80F);
        dac_hiz = 8'hFF; #1;
        check("R4 all", pin_oe, 12'hFFF);

        // R5/R6: capture, then change pins
        pin_in = 12'h3C9;
        step({12'h000, 4'b1110}, 1'b1);
        check("R5 data", cap_data, 12'h3C9);
        check("R5 valid", {11'b0, cap_valid}, 12'h001);
        pin_in = 12'h555;
        step(16'h0000, 1'b0);
        check("R6 hold", cap_data, 12'h3C9);
        check("R6 pulse", {11'b0, cap_valid}, 12'h000);

        // R7: unused code and strobe low
        step({12'h777, 4'b0000}, 1'b1);
        check("R7 ignore code", pin_out, 12'h001);
        step({12'h777, 4'b1101}, 1'b0);
        check("R7 no strobe", pin_out, 12'h001);
        step({12'h000, 4'b1111}, 1'b0);
        check("R7 dir kept", pin_oe, 12'hFFF);
        step({12'h000, 4'b1100}, 1'b1);
        check("R7 no valid", {11'b0, cap_valid}, 12'h000);

        // random mix, back-to-back loads
        for (int i = 0; i < 400; i++) begin
            logic [3:0] code;
            int sel;
            sel = $urandom_range(0, 4);
            case (sel)
                0: code = 4'b1101;
                1: code = 4'b1110;
                2: code = 4'b1111;
                default: code = 4'($urandom_range(0, 15));
            endcase
            pin_in  = 12'($urandom);
            dac_hiz = 8'($urandom);
            step({12'($urandom), code}, ($urandom_range(0, 3) != 0));
        end

        done = 1'b1;
        summary();
    end

endmodule